// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer on a small register bus with 16-bit registers. A slow tick input, one pulse every half second, clocks an 8-bit down counter. The counter reloads from the programmed timeout when the watchdog is first enabled. After that, the only way to reload it is to write two key words to the service register, in the right order. If the counter runs out, the block drives a reset to the rest of the chip. The reset is either a one-tick internal reset pulse or a sticky active-low external reset line, chosen by a control bit.

Software can also request a reset directly through the control register. A pre-timeout interrupt can warn software a programmable number of ticks before expiry. The interrupt's status bit is cleared by writing one to it.

A status register records whether the last reset came from a timeout or from software. It survives the ordinary system reset and is cleared only by the power-on reset. Two low-power inputs from the power controller can freeze the count, each only if its suspend bit is set. The low-power and wait-mode suspend bits can be written only once after reset, and the enable bit cannot be cleared by software.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the control register reads 0x0030 (timeout field 0, wait suspend bit 7 = 0, external control bit 5 = 1, software reset bit 4 = 1, reset select bit 3 = 0, enable bit 2 = 0, low-power suspend bit 0 = 0), `int_rst` is 0, `ext_rst_n` is 1 and `irq` is 0.
- R2: Registers are decoded at byte addresses 0x0 (control), 0x2 (service, reads 0), 0x4 (status), 0x6 (interrupt control) and 0x8 (a general 16-bit read/write register). Reads are combinational from `bus_addr`.
- R3: Setting enable (bit 2) loads the timeout field N (bits 15:8) into the counter. With the reset select bit at 0, `int_rst` rises after the (N+1)-th tick that follows. It stays high until the next tick, and the counter reloads from the field.
- R4: Once set, the enable bit reads 1 until reset, whatever is written to it.
- R5: A reload takes place only when 0x5555 is written to the service register and the very next service write is 0xAAAA. Any other value or order leaves the count unchanged.
- R6: A change to the timeout field while enabled takes effect only at the next reload; expiry also reloads.
- R7: Bits 0 and 7 of the control register take their value from the first control write after reset. Later writes leave them unchanged.
- R8: While bit 0 is set and `lp_req` is 1, or while bit 7 is set and `wait_req` is 1, ticks do not change the count.
- R9: In the interrupt control register, bit 15 enables the pre-timeout interrupt, bits 7:0 hold W and bit 14 is the status. The status sets on the tick that leaves W ticks before expiry (when W > 0 and bit 15 is 1). `irq` equals bit 15 AND bit 14, and writing 1 to bit 14 clears the status.
- R10: With reset select bit 3 at 1, expiry drives `ext_rst_n` low without pulsing `int_rst`. The line stays low until reset.
- R11: A control write with bit 4 = 0 raises `int_rst` on the next clock until the next tick. A 0 in bit 5 drives `ext_rst_n` low for as long as bit 5 holds 0.
- R12: Status register bit 1 reads 1 after a timeout reset and bit 0 reads 1 after a software reset; each event clears the other bit. Both survive `rst` and are cleared only by `por`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high system reset |
| por | input | 1 | Synchronous power-on reset, also clears the status register |
| tick | input | 1 | One-cycle pulse every half second |
| lp_req | input | 1 | Low-power mode is active |
| wait_req | input | 1 | Wait mode is active |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Pre-timeout interrupt |
| int_rst | output | 1 | Internal reset request pulse |
| ext_rst_n | output | 1 | Active-low external reset |

## Verification
The hardest situation to reach is the service key logic under broken sequences. The key pair must be interrupted by a foreign word, or the second key must arrive without the first, while the counter is only a tick or two from expiry. Only then does a missed reload show up as an expiry on the very next tick. The bench parks the counter at a known small value by counting ticks from the enable write. It issues the broken sequences, then counts the remaining ticks to the exact expiry edge, and repeats this with a correct pair to see the full reload. The suspend and write-once paths need the first control write after reset to be the one that sets the suspend bit, so those tasks start from a fresh reset.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    localparam int DW = 16;
    localparam int AW = 4;
    localparam int TW = 8;

    localparam logic [AW-1:0] A_CTL = 4'h0;
    localparam logic [AW-1:0] A_SVC = 4'h2;
    localparam logic [AW-1:0] A_STS = 4'h4;
    localparam logic [AW-1:0] A_ICR = 4'h6;
    localparam logic [AW-1:0] A_MSC = 4'h8;

    localparam logic [DW-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [DW-1:0] KEY_SECOND = 16'hAAAA;

    typedef struct packed {
        logic [TW-1:0] tmo;
        logic          wdw;
        logic          ext_n;
        logic          sel;
        logic          en;
        logic          lps;
    } ctl_t;

    typedef struct packed {
        logic          wie;
        logic [TW-1:0] wict;
    } icr_t;

    localparam ctl_t CTL_RESET = '{tmo: '0, wdw: 1'b0, ext_n: 1'b1,
                                   sel: 1'b0, en: 1'b0, lps: 1'b0};

    function automatic logic [DW-1:0] pack_ctl(input ctl_t c);
        return {c.tmo, c.wdw, 1'b0, c.ext_n, 1'b1, c.sel, c.en, 1'b0, c.lps};
    endfunction

    function automatic logic [DW-1:0] pack_icr(input icr_t i, input logic st);
        return {i.wie, st, {(DW-2-TW){1'b0}}, i.wict};
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_keyed_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          pre_hit,
    input  logic [1:0]    sts,
    output ctl_t          ctl,
    output icr_t          icr,
    output logic          wtis,
    output logic          load,
    output logic [TW-1:0] load_val,
    output logic          swr_req,
    output logic [DW-1:0] rdata
);

    ctl_t          ctl_q;
    icr_t          icr_q;
    logic          lock_q;
    logic          armed_q;
    logic          wtis_q;
    logic [DW-1:0] misc_q;

    logic ctl_wr, svc_wr, icr_wr, msc_wr;

    always_comb begin
        ctl_wr = wr && (addr == A_CTL);
        svc_wr = wr && (addr == A_SVC);
        icr_wr = wr && (addr == A_ICR);
        msc_wr = wr && (addr == A_MSC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_RESET;
            lock_q  <= 1'b0;
            armed_q <= 1'b0;
            icr_q   <= '0;
            wtis_q  <= 1'b0;
            misc_q  <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q.tmo   <= wdata[15:8];
                ctl_q.ext_n <= wdata[5];
                ctl_q.sel   <= wdata[3];
                if (wdata[2]) ctl_q.en <= 1'b1;
                if (!lock_q) begin
                    ctl_q.wdw <= wdata[7];
                    ctl_q.lps <= wdata[0];
                    lock_q    <= 1'b1;
                end
            end
            if (svc_wr) armed_q <= (wdata == KEY_FIRST);
            if (icr_wr) begin
                icr_q.wie  <= wdata[15];
                icr_q.wict <= wdata[TW-1:0];
            end
            if (pre_hit)                   wtis_q <= 1'b1;
            else if (icr_wr && wdata[14])  wtis_q <= 1'b0;
            if (msc_wr) misc_q <= wdata;
        end
    end

    always_comb begin
        load = (ctl_wr && wdata[2] && !ctl_q.en) ||
               (svc_wr && (wdata == KEY_SECOND) && armed_q && ctl_q.en);
        load_val = ctl_wr ? wdata[15:8] : ctl_q.tmo;
        swr_req  = ctl_wr && !wdata[4];
        unique case (addr)
            A_CTL:   rdata = pack_ctl(ctl_q);
            A_STS:   rdata = {{(DW-2){1'b0}}, sts};
            A_ICR:   rdata = pack_icr(icr_q, wtis_q);
            A_MSC:   rdata = misc_q;
            default: rdata = '0;
        endcase
    end

    assign ctl  = ctl_q;
    assign icr  = icr_q;
    assign wtis = wtis_q;

    // R4
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.en |=> ctl_q.en);

    // R7
    once_lock_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable({ctl_q.lps, ctl_q.wdw}));

    // R9
    pre_status_chk: assert property (@(posedge clk) disable iff (rst)
        pre_hit |=> wtis_q);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          arm,
    input  logic [TW-1:0] wict,
    output logic          pre_hit,
    output logic          expire
);

    logic [TW-1:0] cnt_q;
    logic          step;

    always_comb begin
        step    = tick && run && !load;
        expire  = step && (cnt_q == '0);
        pre_hit = step && arm && (cnt_q != '0) && (cnt_q == wict);
    end

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (load)      cnt_q <= load_val;
        else if (step)      cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
    end

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !run && !load) |=> $stable(cnt_q));

    // R5
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/wdt_rstout.sv
module wdt_rstout (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       tick,
    input  logic       expire,
    input  logic       sel,
    input  logic       swr_req,
    input  logic       ext_ctl_n,
    output logic       int_rst,
    output logic       ext_rst_n,
    output logic [1:0] sts
);

    logic       int_q;
    logic       ext_q;
    logic [1:0] sts_q;

    always_ff @(posedge clk) begin
        if (rst || por) begin
            int_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            if (swr_req || (expire && !sel)) int_q <= 1'b1;
            else if (tick)                   int_q <= 1'b0;
            if (expire && sel)               ext_q <= 1'b1;
        end
        if (por)           sts_q <= 2'b00;
        else if (expire)   sts_q <= 2'b10;
        else if (swr_req)  sts_q <= 2'b01;
    end

    assign int_rst   = int_q;
    assign ext_rst_n = ext_ctl_n && !ext_q;
    assign sts       = sts_q;

    // R3
    int_expiry_chk: assert property (@(posedge clk) disable iff (rst || por)
        (expire && !sel) |=> int_rst);

    // R10
    ext_expiry_chk: assert property (@(posedge clk) disable iff (rst || por)
        (expire && sel) |=> !ext_rst_n);

    // R11
    swr_pulse_chk: assert property (@(posedge clk) disable iff (rst || por)
        swr_req |=> int_rst);

    // R12
    cause_keep_chk: assert property (@(posedge clk) disable iff (por)
        (!expire && !swr_req) |=> $stable(sts_q));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          por,
    input  logic          tick,
    input  logic          lp_req,
    input  logic          wait_req,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          int_rst,
    output logic          ext_rst_n
);

    ctl_t          ctl;
    icr_t          icr;
    logic          wtis, load, swr_req, pre_hit, expire, run;
    logic [TW-1:0] load_val;
    logic [1:0]    sts;

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .pre_hit(pre_hit), .sts(sts), .ctl(ctl), .icr(icr), .wtis(wtis),
        .load(load), .load_val(load_val), .swr_req(swr_req), .rdata(bus_rdata)
    );

    always_comb run = ctl.en && !((ctl.lps && lp_req) || (ctl.wdw && wait_req));

    wdt_counter #(.TW(TW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .load(load),
        .load_val(load_val), .arm(icr.wie), .wict(icr.wict),
        .pre_hit(pre_hit), .expire(expire)
    );

    wdt_rstout u_rout (
        .clk(clk), .rst(rst), .por(por), .tick(tick), .expire(expire),
        .sel(ctl.sel), .swr_req(swr_req), .ext_ctl_n(ctl.ext_n),
        .int_rst(int_rst), .ext_rst_n(ext_rst_n), .sts(sts)
    );

    assign irq = icr.wie && wtis;

endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1, por = 1'b1, tick = 1'b0, lp_req = 1'b0, wait_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, int_rst, ext_rst_n;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk(clk), .rst(rst), .por(por), .tick(tick), .lp_req(lp_req),
        .wait_req(wait_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .int_rst(int_rst), .ext_rst_n(ext_rst_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic with_por);
        @(negedge clk);
        rst = 1'b1; por = with_por;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; por = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset_state;
        logic [15:0] v;
        do_reset(1'b1);
        rd(4'h0, v);
        chk("R1 ctl", v, 16'h0030);
        chk("R1 outs", {13'b0, int_rst, ext_rst_n, irq}, 16'h0002);
    endtask

    task automatic t_bus;
        logic [15:0] v;
        do_reset(1'b1);
        wr(4'h8, 16'hBEEF);
        rd(4'h8, v);  chk("R2 misc", v, 16'hBEEF);
        wr(4'h2, 16'h1234);
        rd(4'h2, v);  chk("R2 svc reads 0", v, 16'h0000);
        rd(4'h6, v);  chk("R2 icr reset", v, 16'h0000);
    endtask

    task automatic t_expiry;
        logic [15:0] v;
        do_reset(1'b1);
        wr(4'h0, 16'h0334);
        ticks(3);
        chk("R3 before expiry", {15'b0, int_rst}, 16'h0);
        ticks(1);
        chk("R3 expiry pulse", {15'b0, int_rst}, 16'h1);
        ticks(1);
        chk("R3 pulse ends", {15'b0, int_rst}, 16'h0);
        do_reset(1'b0);
        rd(4'h4, v);  chk("R12 timeout cause kept", v, 16'h0002);
        do_reset(1'b1);
        rd(4'h4, v);  chk("R12 por clears", v, 16'h0000);
    endtask

    task automatic t_sticky;
        logic [15:0] v;
        do_reset(1'b1);
        wr(4'h0, 16'h0334);
        wr(4'h0, 16'h0330);
        rd(4'h0, v);
        chk("R4 enable stays", v & 16'h0004, 16'h0004);
    endtask

    task automatic t_service;
        do_reset(1'b1);
        wr(4'h0, 16'h0334);
        ticks(2);
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        ticks(1);
        chk("R5 no reload", {15'b0, int_rst}, 16'h0);
        ticks(1);
        chk("R5 bad key expires", {15'b0, int_rst}, 16'h1);
        do_reset(1'b1);
        wr(4'h0, 16'h0334);
        ticks(2);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);
        ticks(3);
        chk("R5 reloaded", {15'b0, int_rst}, 16'h0);
        ticks(1);
        chk("R5 full period", {15'b0, int_rst}, 16'h1);
    endtask

    task automatic t_field;
        do_reset(1'b1);
        wr(4'h0, 16'h0334);
        wr(4'h0, 16'h0734);
        ticks(4);
        chk("R6 old value used", {15'b0, int_rst}, 16'h1);
        ticks(7);
        chk("R6 new value pending", {15'b0, int_rst}, 16'h0);
        ticks(1);
        chk("R6 new value used", {15'b0, int_rst}, 16'h1);
    endtask

    task automatic t_once;
        logic [15:0] v;
        do_reset(1'b1);
        wr(4'h0, 16'h0330);
        wr(4'h0, 16'h03B1);
        rd(4'h0, v);
        chk("R7 locked at 0", v & 16'h0081, 16'h0000);
        do_reset(1'b1);
        wr(4'h0, 16'h03B1);
        wr(4'h0, 16'h0330);
        rd(4'h0, v);
        chk("R7 locked at 1", v & 16'h0081, 16'h0081);
    endtask

    task automatic t_suspend;
        do_reset(1'b1);
        wr(4'h0, 16'h0331);
        wr(4'h0, 16'h0335);
        lp_req = 1'b1;
        ticks(10);
        chk("R8 held in low power", {15'b0, int_rst}, 16'h0);
        lp_req = 1'b0;
        ticks(3);
        chk("R8 resumes", {15'b0, int_rst}, 16'h0);
        ticks(1);
        chk("R8 expires after resume", {15'b0, int_rst}, 16'h1);
        do_reset(1'b1);
        wr(4'h0, 16'h03B4);
        wait_req = 1'b1;
        ticks(6);
        chk("R8 held in wait", {15'b0, int_rst}, 16'h0);
        wait_req = 1'b0;
        ticks(4);
        chk("R8 wait resumes", {15'b0, int_rst}, 16'h1);
    endtask

    task automatic t_pretimeout;
        logic [15:0] v;
        do_reset(1'b1);
        wr(4'h6, 16'h8002);
        wr(4'h0, 16'h0534);
        ticks(3);
        chk("R9 not yet", {15'b0, irq}, 16'h0);
        ticks(1);
        chk("R9 fires", {15'b0, irq}, 16'h1);
        wr(4'h6, 16'hC002);
        chk("R9 w1c", {15'b0, irq}, 16'h0);
        rd(4'h6, v);  chk("R9 icr after clear", v, 16'h8002);
        ticks(1);
        chk("R9 two ticks left", {15'b0, int_rst}, 16'h0);
        ticks(1);
        chk("R9 expiry", {15'b0, int_rst}, 16'h1);
    endtask

    task automatic t_ext;
        do_reset(1'b1);
        wr(4'h0, 16'h033C);
        ticks(4);
        chk("R10 ext low", {14'b0, ext_rst_n, int_rst}, 16'h0);
        ticks(2);
        chk("R10 ext sticky", {15'b0, ext_rst_n}, 16'h0);
    endtask

    task automatic t_swr;
        logic [15:0] v;
        do_reset(1'b1);
        wr(4'h0, 16'h0020);
        chk("R11 sw reset pulse", {15'b0, int_rst}, 16'h1);
        ticks(1);
        chk("R11 pulse ends", {15'b0, int_rst}, 16'h0);
        do_reset(1'b0);
        rd(4'h4, v);  chk("R12 sw cause", v, 16'h0001);
        wr(4'h0, 16'h0010);
        chk("R11 ext control low", {15'b0, ext_rst_n}, 16'h0);
        wr(4'h0, 16'h0030);
        chk("R11 ext control high", {15'b0, ext_rst_n}, 16'h1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_bus();
        t_expiry();
        t_sticky();
        t_service();
        t_field();
        t_once();
        t_suspend();
        t_pretimeout();
        t_ext();
        t_swr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule